// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is the serial control port of a multi-output differential clock buffer. It watches the two SMBus lines with the system clock, decodes START, repeated START and STOP, and answers one bus address of its own. It holds eight byte-wide registers. Four of them can be written: three control bytes and a byte counter. The other four are read-only. They report the live output-enable pins, a set of pins captured during reset, and two fixed identity codes. The three control bytes drive the clock datapath as plain parallel outputs.

Two command forms are accepted. Command 0x00 starts a block transfer. On a write, the host sends a byte count and then data starting at register 0. On a read, the target first returns the byte counter and then data starting at register 0. A command whose top three bits are 100 selects one register, whose offset is the low five bits. The bus lines are the only data path. There is no valid/ready interface. The target never stretches SCL, so the host's clock alone paces every transfer and there is no back-pressure.

SDA leaves the block as a pull-low request. The pad and the wired-AND with other devices lie outside the block.

Top module: `smb_cfg_regfile`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x68 plus the 3-bit strap value, which gives write-form bytes D0, D2 … DE. The R/W bit is address-byte bit 0, with 0 meaning write. On any other address the target gives no acknowledge and ignores the bus until the next START.
- R2: Reset values are as follows. Byte 0 is {1,1,1,fs,fs,0,~fs,1}, listed from bit 7 down, where fs is the frequency-select pin during reset. Byte 1 is 0xFF. Byte 2 is 0xEF. Byte 7 is 0x07.
- R3: A byte write sends address+W, then command 100ooooo, then one data byte. It stores the data at offset ooooo, and every byte is acknowledged.
- R4: A byte read sends address+W, then command 100ooooo, then repeated START, then address+R. The target returns the register at that offset. Offsets from 8 to 31 return 0x00.
- R5: A block write sends command 0x00, then a byte count, then data. The data is stored from register 0 upward. Data bytes past register 7 are acknowledged and dropped.
- R6: A block read returns byte 7 first and then registers from 0 upward. A position at or past the count, or past register 7, returns 0x00. The read ends when the host does not acknowledge.
- R7: Byte 3 returns output-enable pins 0–7 live, with bit i for pin i. Byte 4 is {fs, bw_n, pll, 0, 0, oe10_11, oe9, oe8}, listed from bit 7 down. The first three of these fields are captured during reset. Byte 5 reads 0x00 and byte 6 reads 0x0C. Writes to bytes 3–6 are acknowledged and have no effect.
- R8: A command byte that is neither 0x00 nor of the form 100xxxxx is not acknowledged, and the rest of the transfer is ignored.
- R9: A STOP or START in the middle of a byte abandons the transfer without a write and releases SDA. The next START begins a fresh transfer.
- R10: The pull on SDA changes only while SCL is low, except for a release at START or STOP. Outside a read data byte, it is asserted only in the ninth clock.
- R11: Writing byte 7 sets the count returned by, and limiting, the next block read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; pins are captured while low |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| addr_strap_i | input | 3 | Address strap pins |
| oe_pin_n_i | input | 11 | Active-low output-enable pins; bit 10 is the shared enable for outputs 10/11 |
| fs_pin_i | input | 1 | Frequency-select pin |
| bw_pin_n_i | input | 1 | Active-low high-bandwidth pin |
| pll_pin_i | input | 1 | PLL/bypass strap pin |
| ctrl0_o | output | 8 | Control byte 0 (gear ratio) |
| ctrl1_o | output | 8 | Control byte 1 (enables 0–7) |
| ctrl2_o | output | 8 | Control byte 2 (enables 8–11, mode bits) |

## Verification
A write into a read-only status byte can commit in the same SCL phase in which the pins behind that byte change. The bench provokes this by rewriting the output-enable pins while the last data bit of a write to byte 3 is on the bus. A later read must return the new pin levels and not the written value. The second collision is between a bus condition and a byte in progress. A STOP or repeated START is issued a few bits into a data byte. The control outputs must stay unchanged, SDA must be released, and the transfer that follows must behave normally.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int NUM_REGS    = 8;
  localparam int OE_PINS     = 11;
  localparam logic [7:0] CMD_BLOCK = 8'h00;
  localparam logic [2:0] CMD_SINGLE_TAG = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0] DEVICE_ID = 8'h0C,
  parameter logic [7:0] VENDOR_ID = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [7:0]         wr_idx_i,
  input  logic [7:0]         wr_data_i,
  input  logic [7:0]         rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic [7:0]         cnt_o,
  input  logic [OE_PINS-1:0] oe_n_i,
  input  logic               fs_i,
  input  logic               bw_n_i,
  input  logic               pll_i,
  output logic [7:0]         ctrl0_o,
  output logic [7:0]         ctrl1_o,
  output logic [7:0]         ctrl2_o
);
  logic fs_l, bw_l, pll_l;
  logic [7:0] stat4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_l    <= fs_i;
      bw_l    <= bw_n_i;
      pll_l   <= pll_i;
      ctrl0_o <= {3'b111, fs_i, fs_i, 1'b0, ~fs_i, 1'b1};
      ctrl1_o <= 8'hFF;
      ctrl2_o <= 8'hEF;
      cnt_o   <= 8'h07;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        8'd0:    ctrl0_o <= wr_data_i;
        8'd1:    ctrl1_o <= wr_data_i;
        8'd2:    ctrl2_o <= wr_data_i;
        8'd7:    cnt_o   <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign stat4 = {fs_l, bw_l, pll_l, 2'b00, oe_n_i[OE_PINS-1:8]};

  always_comb begin
    case (rd_idx_i)
      8'd0:    rd_data_o = ctrl0_o;
      8'd1:    rd_data_o = ctrl1_o;
      8'd2:    rd_data_o = ctrl2_o;
      8'd3:    rd_data_o = oe_n_i[7:0];
      8'd4:    rd_data_o = stat4;
      8'd5:    rd_data_o = VENDOR_ID;
      8'd6:    rd_data_o = DEVICE_ID;
      8'd7:    rd_data_o = cnt_o;
      default: rd_data_o = 8'h00;
    endcase
  end

  // R11: a byte-7 write lands in the counter one cycle later
  a_r11_count_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 8'd7) |=> (cnt_o == $past(wr_data_i)));

  // R7: status bytes absorb writes without touching writable state
  a_r7_ro_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i >= 8'd3 && wr_idx_i <= 8'd6) |=>
      ($stable(ctrl0_o) && $stable(ctrl1_o) && $stable(ctrl2_o) && $stable(cnt_o)));
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [6:0] dev_addr_i,
  output logic [7:0] rd_idx_o,
  input  logic [7:0] rd_data_i,
  input  logic [7:0] cnt_i,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic       sda_pull_o
);
  smb_state_e st;
  logic [3:0] bitcnt;
  logic       rise_seen, cmd_blk, send_cnt;
  logic [7:0] rx_sh, tx_sh, ptr, tx_byte, ptr_inc;

  assign ptr_inc  = (ptr == 8'hFF) ? ptr : ptr + 8'd1;
  assign rd_idx_o = ptr;
  assign tx_byte  = send_cnt ? cnt_i :
                    (cmd_blk && ptr >= cnt_i) ? 8'h00 : rd_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; rise_seen <= 1'b0;
      rx_sh <= '0; tx_sh <= '0; ptr <= '0;
      cmd_blk <= 1'b0; send_cnt <= 1'b0; sda_pull_o <= 1'b0;
      wr_en_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st <= ST_ADDR; bitcnt <= '0; rise_seen <= 1'b0; sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE; rise_seen <= 1'b0; sda_pull_o <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (rise_i) begin
          rise_seen <= 1'b1;
          if (bitcnt != 4'd8) rx_sh <= {rx_sh[6:0], sda_i};
          else if (st == ST_RDATA && sda_i) st <= ST_HOLD;
        end else if (fall_i && rise_seen) begin
          rise_seen <= 1'b0;
          if (bitcnt == 4'd7) begin
            bitcnt     <= 4'd8;
            sda_pull_o <= 1'b0;
            case (st)
              ST_ADDR: begin
                if (rx_sh[7:1] == dev_addr_i) begin
                  sda_pull_o <= 1'b1;
                  if (rx_sh[0]) begin
                    st       <= ST_RDATA;
                    send_cnt <= cmd_blk;
                    if (cmd_blk) ptr <= '0;
                  end else st <= ST_CMD;
                end else st <= ST_HOLD;
              end
              ST_CMD: begin
                if (rx_sh == CMD_BLOCK) begin
                  cmd_blk <= 1'b1; ptr <= '0; sda_pull_o <= 1'b1; st <= ST_COUNT;
                end else if (rx_sh[7:5] == CMD_SINGLE_TAG) begin
                  cmd_blk <= 1'b0; ptr <= {3'b000, rx_sh[4:0]};
                  sda_pull_o <= 1'b1; st <= ST_WDATA;
                end else st <= ST_HOLD;
              end
              ST_COUNT: begin
                sda_pull_o <= 1'b1; st <= ST_WDATA;
              end
              ST_WDATA: begin
                sda_pull_o <= 1'b1;
                wr_en_o    <= 1'b1;
                wr_idx_o   <= ptr;
                wr_data_o  <= rx_sh;
                ptr        <= cmd_blk ? ptr_inc : 8'hFF;
              end
              default: ;
            endcase
          end else if (bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (st == ST_RDATA) begin
              tx_sh      <= tx_byte;
              sda_pull_o <= ~tx_byte[7];
              if (send_cnt) send_cnt <= 1'b0;
              else          ptr      <= ptr_inc;
            end else sda_pull_o <= 1'b0;
          end else begin
            bitcnt <= bitcnt + 4'd1;
            if (st == ST_RDATA) begin
              sda_pull_o <= ~tx_sh[6];
              tx_sh      <= {tx_sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  // R10: the pull only moves while SCL is low, or as a START/STOP release
  a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> (!$past(scl_i) || $past(start_i) || $past(stop_i)));

  // R10: outside read data the pull appears only in the ninth clock
  a_r10_pull_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (bitcnt == 4'd8 || st == ST_RDATA));

  // R9: bus conditions always free the data line
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !sda_pull_o);

  a_r9_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !sda_pull_o);
endmodule

// File: rtl/smb_cfg_regfile.sv
module smb_cfg_regfile
  import smb_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] BASE_ADDR   = 7'h68,
  parameter logic [7:0] DEVICE_ID   = 8'h0C,
  parameter logic [7:0] VENDOR_ID   = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [2:0]         addr_strap_i,
  input  logic [OE_PINS-1:0] oe_pin_n_i,
  input  logic               fs_pin_i,
  input  logic               bw_pin_n_i,
  input  logic               pll_pin_i,
  output logic [7:0]         ctrl0_o,
  output logic [7:0]         ctrl1_o,
  output logic [7:0]         ctrl2_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt;
  logic [6:0] dev_addr;

  assign dev_addr = BASE_ADDR + {4'b0000, addr_strap_i};

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_proto u_proto (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_s), .sda_i(sda_s),
    .rise_i(scl_rise), .fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det),
    .dev_addr_i(dev_addr), .rd_idx_o(rd_idx), .rd_data_i(rd_data), .cnt_i(cnt),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .sda_pull_o(sda_pull_o)
  );

  smb_regs #(.DEVICE_ID(DEVICE_ID), .VENDOR_ID(VENDOR_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .cnt_o(cnt), .oe_n_i(oe_pin_n_i),
    .fs_i(fs_pin_i), .bw_n_i(bw_pin_n_i), .pll_i(pll_pin_i),
    .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o)
  );
endmodule

// File: tb/test_smb_cfg_regfile.sv
module test_smb_cfg_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [2:0] strap = 3'b101;
  logic [10:0] oe_n = 11'h5A3;
  logic fs = 1'b1, bw_n = 1'b0, pll = 1'b1;
  logic [7:0] ctrl0, ctrl1, ctrl2;
  logic [7:0] exp_q [16];
  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [7:0] AW = 8'hDA;
  localparam logic [7:0] AR = 8'hDB;

  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  smb_cfg_regfile i_smb_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_strap_i(strap), .oe_pin_n_i(oe_n), .fs_pin_i(fs), .bw_pin_n_i(bw_n),
    .pll_pin_i(pll), .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .ctrl2_o(ctrl2)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    scl = 0; w(5); sda_m = 1; w(5); scl = 1; w(10); sda_m = 0; w(10);
  endtask

  task automatic bus_stop;
    scl = 0; w(5); sda_m = 0; w(5); scl = 1; w(10); sda_m = 1; w(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl = 0; w(5); sda_m = b[i]; w(5); scl = 1; w(10);
    end
  endtask

  task automatic get_ack(output logic a);
    scl = 0; w(5); sda_m = 1; w(5); scl = 1; w(5); a = ~sda_line; w(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    send_bits(b, 8);
    get_ack(a);
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 0; w(5); sda_m = 1; w(5); scl = 1; w(5); b[i] = sda_line; w(5);
    end
    scl = 0; w(5); sda_m = ~ack; w(5); scl = 1; w(10);
  endtask

  task automatic wr_single(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start;
    send_byte(AW, a0); send_byte(cmd, a1); send_byte(d, a2);
    bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_single(input logic [7:0] cmd, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start;
    send_byte(AW, a0); send_byte(cmd, a1);
    bus_start;
    send_byte(AR, a2);
    recv_byte(1'b0, d);
    bus_stop;
  endtask

  task automatic t_reset;
    check("R2 ctrl0 reset", ctrl0, 8'hF9);
    check("R2 ctrl1 reset", ctrl1, 8'hFF);
    check("R2 ctrl2 reset", ctrl2, 8'hEF);
    check("R10 sda released at reset", {7'd0, sda_pull}, 8'h00);
  endtask

  task automatic t_wrong_addr;
    logic a;
    bus_start;
    send_byte(8'hD8, a);
    check("R1 foreign address not acked", {7'd0, a}, 8'h00);
    send_byte(8'h81, a);
    send_byte(8'h00, a);
    bus_stop;
    check("R1 foreign transfer ignored", ctrl1, 8'hFF);
  endtask

  task automatic t_byte_write;
    logic ok;
    wr_single(8'h81, 8'h3C, ok);
    check("R3 byte write acked", {7'd0, ok}, 8'h01);
    check("R3 byte write stored", ctrl1, 8'h3C);
  endtask

  task automatic t_byte_read;
    logic [7:0] d;
    rd_single(8'h82, d);
    check("R4 byte read offset 2", d, 8'hEF);
    rd_single(8'h87, d);
    check("R2 counter reset value", d, 8'h07);
    rd_single(8'h9F, d);
    check("R4 offset 31 reads zero", d, 8'h00);
  endtask

  task automatic t_ro;
    logic [7:0] d;
    logic ok, a0, a1, a2;
    rd_single(8'h83, d);
    check("R7 byte3 live oe pins", d, 8'hA3);
    rd_single(8'h84, d);
    check("R7 byte4 latched pins", d, 8'hA5);
    rd_single(8'h85, d);
    check("R7 byte5 id", d, 8'h00);
    rd_single(8'h86, d);
    check("R7 byte6 id", d, 8'h0C);
    // write to byte 3 while its pins change in the last data bit
    bus_start;
    send_byte(AW, a0); send_byte(8'h83, a1);
    send_bits(8'hFF, 8);
    oe_n[7:0] = 8'h5C;
    get_ack(a2);
    bus_stop;
    ok = a0 & a1 & a2;
    check("R7 read-only write acked", {7'd0, ok}, 8'h01);
    rd_single(8'h83, d);
    check("R7 byte3 shows new pins not write", d, 8'h5C);
    check("R7 ctrl unchanged", ctrl1, 8'h3C);
  endtask

  task automatic t_bad_cmd;
    logic a0, a1, a2;
    bus_start;
    send_byte(AW, a0); send_byte(8'h40, a1); send_byte(8'h55, a2);
    bus_stop;
    check("R8 invalid command nacked", {7'd0, a1}, 8'h00);
    check("R8 invalid command no write", ctrl0, 8'hF9);
  endtask

  task automatic t_block_write;
    logic a, all;
    all = 1;
    bus_start;
    send_byte(AW, a); all &= a;
    send_byte(8'h00, a); all &= a;
    send_byte(8'd10, a); all &= a;
    for (int i = 0; i < 10; i++) begin
      send_byte((i == 7) ? 8'h05 : 8'((i + 1) * 17), a);
      all &= a;
    end
    bus_stop;
    check("R5 block write all acked", {7'd0, all}, 8'h01);
    check("R5 block byte0", ctrl0, 8'h11);
    check("R5 block byte1", ctrl1, 8'h22);
    check("R5 block byte2", ctrl2, 8'h33);
  endtask

  task automatic t_block_read(input int n, input string req);
    logic a0, a1, a2;
    logic [7:0] d;
    bus_start;
    send_byte(AW, a0); send_byte(8'h00, a1);
    bus_start;
    send_byte(AR, a2);
    recv_byte(1'b1, d);
    check({req, " count byte"}, d, exp_q[0]);
    for (int i = 1; i <= n; i++) begin
      recv_byte(i != n, d);
      check({req, " data byte"}, d, exp_q[i]);
    end
    bus_stop;
  endtask

  task automatic t_block_reads;
    logic ok;
    exp_q[0] = 8'h05; exp_q[1] = 8'h11; exp_q[2] = 8'h22; exp_q[3] = 8'h33;
    exp_q[4] = 8'h5C; exp_q[5] = 8'hA5; exp_q[6] = 8'h00; exp_q[7] = 8'h00;
    t_block_read(7, "R11 count from block write, R6");
    wr_single(8'h87, 8'h0A, ok);
    exp_q[0] = 8'h0A; exp_q[7] = 8'h0C; exp_q[8] = 8'h0A;
    exp_q[9] = 8'h00; exp_q[10] = 8'h00; exp_q[6] = 8'h00;
    t_block_read(10, "R6 read past byte 7");
  endtask

  task automatic t_abort;
    logic a0, a1, a2, ok;
    logic [7:0] d;
    bus_start;
    send_byte(AW, a0); send_byte(8'h81, a1);
    send_bits(8'h00, 4);
    bus_stop;
    check("R9 stop mid-byte no write", ctrl1, 8'h22);
    check("R9 line released", {7'd0, sda_line}, 8'h01);
    rd_single(8'h81, d);
    check("R9 next transfer after stop", d, 8'h22);
    bus_start;
    send_byte(AW, a0); send_byte(8'h81, a1);
    send_bits(8'hFF, 3);
    bus_start;
    send_byte(AW, a0); send_byte(8'h81, a1); send_byte(8'h77, a2);
    bus_stop;
    ok = a0 & a1 & a2;
    check("R9 restart mid-byte acked", {7'd0, ok}, 8'h01);
    check("R9 restart mid-byte write", ctrl1, 8'h77);
  endtask

  initial begin
    w(10);
    rst_n = 1'b1;
    w(10);
    t_reset;
    t_wrong_addr;
    t_byte_write;
    t_byte_read;
    t_ro;
    t_bad_cmd;
    t_block_write;
    t_block_reads;
    t_abort;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule